// File: doc/BRIEF.md
# Full-Bridge Motor Drive Control Core

This block is the digital core of a DC motor full-bridge driver. It turns four control inputs into gate commands for the two half-bridge legs. The inputs are run (sleep release), phase (direction), enable and decay select. Each leg is either sourcing (high side on), sinking (low side on) or floating (both off). Gate drive, the charge pump, the supply regulators and current sensing are outside the block. They reach it only as single-bit flags: over-temperature, pump undervoltage, regulator undervoltage, power-up lockout and a zero-current comparator.

With enable high the bridge drives the motor in the direction picked by phase. With enable low it decays the winding current. Slow decay sinks both legs, which brakes the motor by shorting its back-EMF. Fast decay reverses the leg polarity with synchronous rectification. Once the zero-current comparator fires, fast decay floats the bridge so that the current cannot reverse.

Any fault flag, the lockout flag, sleep, and a wake window after leaving sleep all float the bridge. A per-leg dead time keeps the two switches of one leg from ever conducting together.

Top module: `hbridge_core`

## Requirements
- R1: With run, enable and phase all high, leg A sources and leg B sinks, whatever decay select is.
- R2: With run and enable high and phase low, leg A sinks and leg B sources.
- R3: With run high, enable low and decay select high (slow decay), both legs sink, whatever phase is.
- R4: With run high, enable low and decay select low (fast decay), phase high makes leg A sink and leg B source. Phase low makes leg A source and leg B sink.
- R5: In fast decay, a high zero-current input floats both legs. The float is held after the input drops, and is released when phase changes or the fast-decay input combination is left. The zero-current input has no effect outside fast decay.
- R6: Run low floats both legs. From the edge after run falls, the pump enable and the low-side supply enable are low. Both enables go high at the edge after run rises.
- R7: Over-temperature, pump undervoltage or regulator undervoltage floats both legs while it is high. Decoding resumes without other action once all flags are low.
- R8: A high power-up lockout input floats both legs while it is high.
- R9: After run rises, both legs stay floating for WAKE = CLK_HZ/1e6*WAKE_US clock edges. They first drive at edge WAKE+1. The window also runs after reset.
- R10: When a leg changes between sourcing and sinking, it floats for exactly DEAD_CYCLES clock cycles in between. A return to the side last driven needs no gap.
- R11: Each leg is brought out as a high-side enable and a low-side enable: 10 sources, 01 sinks, 00 floats, and 11 never appears. Legs float during reset, and outputs change one clock after the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| runIn | input | 1 | High for normal operation, low for sleep |
| phaseIn | input | 1 | Direction select |
| enableIn | input | 1 | High drives, low decays |
| decayIn | input | 1 | Decay select: high slow, low fast |
| zeroCur | input | 1 | Zero-current comparator flag |
| overTemp | input | 1 | Over-temperature flag |
| pumpLow | input | 1 | Charge pump undervoltage flag |
| regLow | input | 1 | Regulator undervoltage flag |
| uvloIn | input | 1 | Power-up lockout flag |
| legAHi | output | 1 | Leg A high-side gate enable |
| legALo | output | 1 | Leg A low-side gate enable |
| legBHi | output | 1 | Leg B high-side gate enable |
| legBLo | output | 1 | Leg B low-side gate enable |
| pumpEn | output | 1 | Charge pump enable |
| lowSupplyEn | output | 1 | Low-side gate supply enable |

## Verification
Fault gating and the zero-current float can both apply in the same cycle. The bench provokes this in fast decay by raising over-temperature and zero-current on the same clock. It then drops both together, so the bridge has to stay floating on the held zero-current state alone. It stays floating until a phase change releases it. The bridge then takes the reversed fast-decay polarity, which shows that the two float paths stay separate and that neither one masks the other.

// File: rtl/hb_pkg.sv
package hb_pkg;
  // bit 1: high-side gate, bit 0: low-side gate
  typedef enum logic [1:0] {
    LEG_OFF = 2'b00,
    LEG_LO  = 2'b01,
    LEG_HI  = 2'b10
  } leg_e;

  typedef struct packed {
    logic driveOk;   // supplies good, awake, no fault
    logic fastKill;  // zero-current float in fast decay
  } strobe_t;
endpackage

// File: rtl/hb_ctrl.sv
module hb_ctrl
  import hb_pkg::*;
#(
  parameter int unsigned WAKE = 100
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    runIn,
  input  logic    phaseIn,
  input  logic    enableIn,
  input  logic    decayIn,
  input  logic    zeroCur,
  input  logic    overTemp,
  input  logic    pumpLow,
  input  logic    regLow,
  input  logic    uvloIn,
  output strobe_t strb,
  output logic    pumpEn,
  output logic    lowSupplyEn
);
  localparam int unsigned WW = $clog2(WAKE + 1);
  localparam logic [WW-1:0] WAKE_LOAD = WW'(WAKE);

  logic [WW-1:0] wakeCnt;
  logic          phaseQ;
  logic          hizQ;
  logic          fastCombo;
  logic          anyFault;
  logic          awake;

  assign fastCombo = runIn && !enableIn && !decayIn;
  assign anyFault  = overTemp || pumpLow || regLow || uvloIn;
  assign awake     = runIn && (wakeCnt == '0);

  always_comb begin
    strb.driveOk  = awake && !anyFault;
    strb.fastKill = fastCombo && (zeroCur || (hizQ && (phaseIn == phaseQ)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeCnt     <= WAKE_LOAD;
      phaseQ      <= 1'b0;
      hizQ        <= 1'b0;
      pumpEn      <= 1'b0;
      lowSupplyEn <= 1'b0;
    end else begin
      if (!runIn)              wakeCnt <= WAKE_LOAD;
      else if (wakeCnt != '0)  wakeCnt <= wakeCnt - 1'b1;
      phaseQ      <= phaseIn;
      hizQ        <= strb.fastKill;
      pumpEn      <= runIn;
      lowSupplyEn <= runIn;
    end
  end

  // R9: the edge run rises on never finds the bridge allowed to drive
  p_wake_block_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runIn) |-> !strb.driveOk);

  // R6: sleep drops the supply enables at the next edge
  p_sleep_supply_r6: assert property (@(posedge clk) disable iff (!rstN)
    !runIn |=> (!pumpEn && !lowSupplyEn));
endmodule

// File: rtl/hb_leg.sv
module hb_leg
  import hb_pkg::*;
#(
  parameter int unsigned DEAD = 3
) (
  input  logic clk,
  input  logic rstN,
  input  leg_e tgt,
  output leg_e cur
);
  localparam int unsigned CW = $clog2(DEAD + 1);
  localparam logic [CW-1:0] GAP_MAX = CW'(DEAD - 1);

  leg_e          lastSide;
  logic [CW-1:0] gap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cur      <= LEG_OFF;
      lastSide <= LEG_LO;
      gap      <= GAP_MAX;
    end else if (tgt == cur) begin
      if (cur == LEG_OFF && gap < GAP_MAX) gap <= gap + 1'b1;
    end else if (cur != LEG_OFF) begin
      cur      <= LEG_OFF;     // switching off is always safe
      lastSide <= cur;
      gap      <= '0;
    end else if (tgt == lastSide || gap >= GAP_MAX) begin
      cur <= tgt;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  // R10: a leg never steps straight from one side to the other
  p_no_shoot_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cur == LEG_HI) |=> (cur != LEG_LO));
  p_no_shoot_b_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cur == LEG_LO) |=> (cur != LEG_HI));
  // R11: both gates of one leg are never on together
  p_enc_r11: assert property (@(posedge clk) disable iff (!rstN)
    cur != 2'b11);
endmodule

// File: rtl/hb_path.sv
module hb_path
  import hb_pkg::*;
#(
  parameter int unsigned DEAD = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  input  logic    phaseIn,
  input  logic    enableIn,
  input  logic    decayIn,
  output leg_e    legA,
  output leg_e    legB
);
  localparam int unsigned LEGS = 2;

  leg_e tgt [LEGS];
  leg_e cur [LEGS];

  always_comb begin
    if (!strb.driveOk || strb.fastKill) begin
      tgt[0] = LEG_OFF; tgt[1] = LEG_OFF;
    end else if (enableIn) begin
      tgt[0] = phaseIn ? LEG_HI : LEG_LO;
      tgt[1] = phaseIn ? LEG_LO : LEG_HI;
    end else if (decayIn) begin
      tgt[0] = LEG_LO; tgt[1] = LEG_LO;
    end else begin
      tgt[0] = phaseIn ? LEG_LO : LEG_HI;
      tgt[1] = phaseIn ? LEG_HI : LEG_LO;
    end
  end

  for (genvar g = 0; g < LEGS; g++) begin : gLeg
    hb_leg #(.DEAD(DEAD)) uLeg (
      .clk  (clk),
      .rstN (rstN),
      .tgt  (tgt[g]),
      .cur  (cur[g])
    );
  end

  assign legA = cur[0];
  assign legB = cur[1];

  // R7/R5: a gating strobe floats both legs by the next edge
  p_gate_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.driveOk || strb.fastKill) |=> (legA == LEG_OFF && legB == LEG_OFF));
endmodule

// File: rtl/hbridge_core.sv
module hbridge_core
  import hb_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned WAKE_US     = 1000,
  parameter int unsigned DEAD_CYCLES = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic runIn,
  input  logic phaseIn,
  input  logic enableIn,
  input  logic decayIn,
  input  logic zeroCur,
  input  logic overTemp,
  input  logic pumpLow,
  input  logic regLow,
  input  logic uvloIn,
  output logic legAHi,
  output logic legALo,
  output logic legBHi,
  output logic legBLo,
  output logic pumpEn,
  output logic lowSupplyEn
);
  localparam int unsigned WAKE = (CLK_HZ / 1_000_000) * WAKE_US;

  strobe_t strb;
  leg_e    legA;
  leg_e    legB;

  hb_ctrl #(.WAKE(WAKE)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .runIn       (runIn),
    .phaseIn     (phaseIn),
    .enableIn    (enableIn),
    .decayIn     (decayIn),
    .zeroCur     (zeroCur),
    .overTemp    (overTemp),
    .pumpLow     (pumpLow),
    .regLow      (regLow),
    .uvloIn      (uvloIn),
    .strb        (strb),
    .pumpEn      (pumpEn),
    .lowSupplyEn (lowSupplyEn)
  );

  hb_path #(.DEAD(DEAD_CYCLES)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .phaseIn  (phaseIn),
    .enableIn (enableIn),
    .decayIn  (decayIn),
    .legA     (legA),
    .legB     (legB)
  );

  assign {legAHi, legALo} = legA;
  assign {legBHi, legBLo} = legB;
endmodule

// File: tb/sim_hbridge_core.sv
module sim_hbridge_core;
  localparam int unsigned WAKE = 100;   // 1 us at 100 MHz
  localparam int unsigned DEAD = 3;
  localparam int unsigned SETTLE = 10;

  typedef struct {
    logic [1:0] a;
    logic [1:0] b;
    logic       sup;
    string      tag;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runIn = 1'b0, phaseIn = 1'b0, enableIn = 1'b0, decayIn = 1'b0;
  logic zeroCur = 1'b0, overTemp = 1'b0, pumpLow = 1'b0, regLow = 1'b0, uvloIn = 1'b0;
  logic legAHi, legALo, legBHi, legBLo, pumpEn, lowSupplyEn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  item_t q[$];

  localparam logic [1:0] OFF = 2'b00, SNK = 2'b01, SRC = 2'b10;

  always #5 clk = ~clk;

  hbridge_core #(.CLK_HZ(100_000_000), .WAKE_US(1), .DEAD_CYCLES(DEAD)) u0 (
    .clk(clk), .rstN(rstN), .runIn(runIn), .phaseIn(phaseIn),
    .enableIn(enableIn), .decayIn(decayIn), .zeroCur(zeroCur),
    .overTemp(overTemp), .pumpLow(pumpLow), .regLow(regLow), .uvloIn(uvloIn),
    .legAHi(legAHi), .legALo(legALo), .legBHi(legBHi), .legBLo(legBLo),
    .pumpEn(pumpEn), .lowSupplyEn(lowSupplyEn)
  );

  // driver side: wait n rising edges, then queue what must be seen
  task automatic expectAfter(int n, logic [1:0] a, logic [1:0] b, logic sup, string tag);
    item_t it;
    repeat (n) @(posedge clk);
    #1;
    it.a = a; it.b = b; it.sup = sup; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  // monitor: compare at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if ({legAHi, legALo} !== it.a || {legBHi, legBLo} !== it.b ||
            pumpEn !== it.sup || lowSupplyEn !== it.sup ||
            (legAHi & legALo) || (legBHi & legBLo)) begin
          errors++;
          $display("FAIL %s: got A=%b B=%b sup=%b/%b, expected A=%b B=%b sup=%b",
                   it.tag, {legAHi, legALo}, {legBHi, legBLo}, pumpEn, lowSupplyEn,
                   it.a, it.b, it.sup);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    expectAfter(1, OFF, OFF, 1'b0, "R11 reset state");

    // wake window (R9)
    @(negedge clk);
    runIn = 1'b1; enableIn = 1'b1; phaseIn = 1'b1;
    expectAfter(WAKE, OFF, OFF, 1'b1, "R9 still inhibited at edge WAKE");
    expectAfter(1, SRC, SNK, 1'b1, "R9/R1 drives at edge WAKE+1");

    decayIn = 1'b1;
    expectAfter(SETTLE, SRC, SNK, 1'b1, "R1 forward, decay high");

    // reverse with exact dead time (R10)
    phaseIn = 1'b0;
    expectAfter(DEAD, OFF, OFF, 1'b1, "R10 legs float during dead time");
    expectAfter(1, SNK, SRC, 1'b1, "R10/R2 reverse after dead time");

    // brake (R3)
    enableIn = 1'b0; decayIn = 1'b1;
    expectAfter(SETTLE, SNK, SNK, 1'b1, "R3 brake phase low");
    phaseIn = 1'b1;
    expectAfter(SETTLE, SNK, SNK, 1'b1, "R3 brake phase high");

    // fast decay (R4)
    decayIn = 1'b0;
    expectAfter(SETTLE, SNK, SRC, 1'b1, "R4 fast decay phase high");
    phaseIn = 1'b0;
    expectAfter(SETTLE, SRC, SNK, 1'b1, "R4 fast decay phase low");

    // zero-current float, hold, release on phase change (R5)
    zeroCur = 1'b1;
    expectAfter(SETTLE, OFF, OFF, 1'b1, "R5 zero current floats");
    zeroCur = 1'b0;
    expectAfter(SETTLE, OFF, OFF, 1'b1, "R5 float held");
    phaseIn = 1'b1;
    expectAfter(SETTLE, SNK, SRC, 1'b1, "R5 released by phase change");
    zeroCur = 1'b1;
    expectAfter(SETTLE, OFF, OFF, 1'b1, "R5 float again");
    zeroCur = 1'b0; decayIn = 1'b1;
    expectAfter(SETTLE, SNK, SNK, 1'b1, "R5 released by leaving fast decay");
    decayIn = 1'b0;
    expectAfter(SETTLE, SNK, SRC, 1'b1, "R5 stays released on return");

    // zero current ignored while driving
    enableIn = 1'b1; zeroCur = 1'b1;
    expectAfter(SETTLE, SRC, SNK, 1'b1, "R5 zero current ignored in forward");
    zeroCur = 1'b0;

    // faults (R7) and lockout (R8)
    overTemp = 1'b1;
    expectAfter(SETTLE, OFF, OFF, 1'b1, "R7 over-temperature floats");
    overTemp = 1'b0;
    expectAfter(SETTLE, SRC, SNK, 1'b1, "R7 resume after over-temperature");
    pumpLow = 1'b1;
    expectAfter(SETTLE, OFF, OFF, 1'b1, "R7 pump undervoltage floats");
    pumpLow = 1'b0; regLow = 1'b1;
    expectAfter(SETTLE, OFF, OFF, 1'b1, "R7 regulator undervoltage floats");
    regLow = 1'b0;
    expectAfter(SETTLE, SRC, SNK, 1'b1, "R7 resume after undervoltage");
    uvloIn = 1'b1;
    expectAfter(SETTLE, OFF, OFF, 1'b1, "R8 lockout floats");
    uvloIn = 1'b0;
    expectAfter(SETTLE, SRC, SNK, 1'b1, "R8 resume after lockout");

    // fault and zero-current in the same cycle (R7 with R5)
    enableIn = 1'b0; decayIn = 1'b0; phaseIn = 1'b1;
    expectAfter(SETTLE, SNK, SRC, 1'b1, "R4 fast decay before overlap");
    overTemp = 1'b1; zeroCur = 1'b1;
    expectAfter(SETTLE, OFF, OFF, 1'b1, "R7 fault with zero current");
    overTemp = 1'b0; zeroCur = 1'b0;
    expectAfter(SETTLE, OFF, OFF, 1'b1, "R5 float held past fault clear");
    phaseIn = 1'b0;
    expectAfter(SETTLE, SRC, SNK, 1'b1, "R5 phase change releases after overlap");

    // sleep (R6) and second wake
    runIn = 1'b0;
    expectAfter(1, OFF, OFF, 1'b0, "R6 sleep floats and drops supplies");
    expectAfter(SETTLE, OFF, OFF, 1'b0, "R6 sleep held");
    enableIn = 1'b1; phaseIn = 1'b1;
    expectAfter(SETTLE, OFF, OFF, 1'b0, "R6 inputs ignored in sleep");
    runIn = 1'b1;
    expectAfter(WAKE, OFF, OFF, 1'b1, "R9 second wake inhibited");
    expectAfter(1, SRC, SNK, 1'b1, "R9 second wake drives");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule